// File: doc/BRIEF.md
# Artificial Trigger Sequencer

This block produces calibration triggers on a fixed millisecond grid. A prescaler turns the core clock into microsecond ticks, and a second counter turns those into millisecond ticks. An interval counter fires once every programmed number of milliseconds. At each firing the sequencer picks the next trigger kind from a repeating pattern and emits a one-cycle pulse with a 2-bit kind code. For light-pulse kinds it also presents the LED-group enables and the drive intensity that belong to that kind.

The pattern has three kinds in a fixed order: pedestal, then internal light pulse, then external light pulse. One 15-bit word holds a 5-bit repeat count for each kind. A kind with a zero count, or with its enable bit cleared, drops out of the pattern. The remaining kinds keep their order and their repeat counts. While the run enable is low the block produces nothing, and the pacing counters and the pattern position return to their start.

Top module: `art_trig_seq`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs are zero after that edge and no pulse is produced.
- R2: With run_en held high from some edge, trig_pulse is high for exactly one cycle, after the j-th edge of multiples of interval_ms × CLK_PER_US × US_PER_MS edges counted from the first edge at which run_en was sampled high. It is low on all other edges.
- R3: An interval_ms of 0 behaves as 1 ms.
- R4: seq_word[14:10] is the pedestal count, seq_word[9:5] the internal light-pulse count, and seq_word[4:0] the external light-pulse count. Triggers are issued as that many pedestal triggers, then that many internal light-pulse triggers, then that many external light-pulse triggers, and the pattern then repeats.
- R5: A kind whose count is 0, or whose kind_en bit is 0, is skipped. kind_en bit 0 is pedestal, bit 1 is internal light pulse and bit 2 is external light pulse.
- R6: When no kind is both enabled and non-zero, no pulse is ever produced.
- R7: trig_kind is 1 for pedestal, 2 for internal light pulse and 3 for external light pulse while trig_pulse is high. It is 0 when trig_pulse is low.
- R8: During a pulse of an internal or external light-pulse kind, led_grp[0] equals bit 6 and led_grp[1] equals bit 7 of that kind's group-enable byte, and led_level equals that kind's 7-bit intensity. During a pedestal pulse, and whenever trig_pulse is low, both are 0.
- R9: While run_en is low no pulse is produced. Raising run_en again restarts both the interval timing of R2 and the pattern at its first kind.
- R10: A count of 31, the largest value, produces 31 consecutive triggers of that kind per pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Enables trigger generation; low clears the pacing and the pattern position |
| interval_ms | input | 10 | Trigger spacing in milliseconds (0 treated as 1) |
| seq_word | input | 15 | Three packed 5-bit repeat counts |
| kind_en | input | 3 | Per-kind enables: pedestal, internal, external |
| lpint_grp_en | input | 8 | Internal light-pulse LED groups (bit 6 group 1, bit 7 group 2) |
| lpext_grp_en | input | 8 | External light-pulse LED groups (bit 6 group 1, bit 7 group 2) |
| lpint_level | input | 7 | Internal light-pulse intensity |
| lpext_level | input | 7 | External light-pulse intensity |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| trig_kind | output | 2 | Kind code, valid with trig_pulse |
| led_grp | output | 2 | LED-group enables for the current pulse |
| led_level | output | 7 | Intensity for the current pulse |

## Verification
A pulse is due exactly one edge after the cycle in which the millisecond tick meets the interval count. Counted from the first edge that samples run_en high, that is edge j × interval × CLK_PER_US × US_PER_MS. The bench counts edges from the moment it raises run_en and samples on the falling edge after each rising edge. It compares every sample with a pulse due that edge, and any pulse that is not due, against kind and LED values worked out from the pattern position. Each run ends with a pulse-count check. The run enable is then lowered for a few edges, during which the outputs must stay silent.

// File: rtl/art_trig_pkg.sv
// Shared types and constants for the artificial trigger sequencer.
package art_trig_pkg;
    localparam int NUM_KINDS = 3;
    localparam int KIND_W    = 2;
    localparam int GRP1_BIT  = 6;
    localparam int GRP2_BIT  = 7;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE  = 2'd0,
        KIND_PED   = 2'd1,
        KIND_LPINT = 2'd2,
        KIND_LPEXT = 2'd3
    } trig_kind_e;
endpackage

// File: rtl/ms_pacer.sv
// Millisecond pacer: divides the clock to microsecond ticks, then to
// millisecond ticks. Assumes CLK_PER_US and US_PER_MS are at least 1.
// Both counters are held at zero while run_en is low.
module ms_pacer #(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic ms_tick
);
    localparam int PRE_W = $clog2(CLK_PER_US > 1 ? CLK_PER_US : 2);
    localparam int US_W  = $clog2(US_PER_MS > 1 ? US_PER_MS : 2);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             us_tick;

    assign us_tick = run_en && (pre_q == PRE_W'(CLK_PER_US - 1));
    assign ms_tick = us_tick && (us_q == US_W'(US_PER_MS - 1));

    // Clock prescaler producing the microsecond tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)  pre_q <= '0;
        else if (us_tick)       pre_q <= '0;
        else                    pre_q <= pre_q + PRE_W'(1);
    end

    // Microsecond counter producing the millisecond tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)  us_q <= '0;
        else if (ms_tick)       us_q <= '0;
        else if (us_tick)       us_q <= us_q + US_W'(1);
    end

    a_r9_prescale_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pre_q == '0 && us_q == '0));
endmodule

// File: rtl/interval_gate.sv
// Interval gate: counts millisecond ticks and raises fire in the cycle
// where the count reaches the programmed interval. Treats an interval of
// 0 as 1. Clears the count while run_en is low.
module interval_gate #(
    parameter int IV_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            ms_tick,
    input  logic [IV_W-1:0] interval,
    output logic            fire
);
    logic [IV_W-1:0] ms_q;
    logic [IV_W-1:0] last_ms;

    assign last_ms = (interval == '0) ? '0 : interval - IV_W'(1);
    assign fire    = ms_tick && (ms_q >= last_ms);

    // Millisecond count since the last firing.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)  ms_q <= '0;
        else if (fire)          ms_q <= '0;
        else if (ms_tick)       ms_q <= ms_q + IV_W'(1);
    end

    a_r9_interval_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (ms_q == '0));
endmodule

// File: rtl/kind_stepper.sv
// Kind stepper: keeps the pattern position (current kind, repeats done)
// and picks the kind issued at each firing. Kinds run in index order with
// wrap-around. A kind is active when it is enabled and its count is non-zero.
module kind_stepper #(
    parameter int NK    = 3,
    parameter int CNT_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     fire,
    input  logic [NK-1:0][CNT_W-1:0] counts,
    input  logic [NK-1:0]            kind_on,
    output logic                     issue,
    output logic [$clog2(NK)-1:0]    issue_idx
);
    localparam int IDX_W = $clog2(NK);

    logic [NK-1:0]    active;
    logic [IDX_W-1:0] cur_q;
    logic [CNT_W-1:0] rep_q;
    logic             stay_ok;
    logic             found;
    logic [IDX_W-1:0] cand;
    int               nx;

    for (genvar k = 0; k < NK; k++) begin : g_active
        assign active[k] = kind_on[k] && (counts[k] != '0);
    end

    // Choose the kind to issue: the current one if repeats remain,
    // otherwise the next active kind in order.
    always_comb begin
        stay_ok = active[cur_q] && (rep_q < counts[cur_q]);
        found   = 1'b0;
        cand    = cur_q;
        nx      = 0;
        for (int k = 1; k <= NK; k++) begin
            nx = (int'(cur_q) + k) % NK;
            if (!found && active[nx]) begin
                found = 1'b1;
                cand  = IDX_W'(nx);
            end
        end
        issue_idx = stay_ok ? cur_q : cand;
        issue     = fire && (stay_ok || found);
    end

    // Pattern position update.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            cur_q <= '0;
            rep_q <= '0;
        end else if (issue) begin
            cur_q <= issue_idx;
            rep_q <= (stay_ok ? rep_q : '0) + CNT_W'(1);
        end
    end

    a_r9_position_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cur_q == '0 && rep_q == '0));
    a_r4_repeat_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && run_en) |=> (rep_q != '0));
endmodule

// File: rtl/art_trig_seq.sv
// Artificial trigger sequencer top. Paces triggers on a millisecond grid,
// steps through pedestal / internal / external light-pulse kinds according
// to packed repeat counts, and registers the pulse, the kind code and the
// LED settings. Assumes the configuration inputs are quasi-static.
module art_trig_seq
    import art_trig_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int US_PER_MS  = 1000,
    parameter int IV_W       = 10,
    parameter int CNT_W      = 5,
    parameter int LVL_W      = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_en,
    input  logic [IV_W-1:0]           interval_ms,
    input  logic [NUM_KINDS*CNT_W-1:0] seq_word,
    input  logic [NUM_KINDS-1:0]      kind_en,
    input  logic [7:0]                lpint_grp_en,
    input  logic [7:0]                lpext_grp_en,
    input  logic [LVL_W-1:0]          lpint_level,
    input  logic [LVL_W-1:0]          lpext_level,
    output logic                      trig_pulse,
    output logic [KIND_W-1:0]         trig_kind,
    output logic [1:0]                led_grp,
    output logic [LVL_W-1:0]          led_level
);
    localparam int IDX_W = $clog2(NUM_KINDS);

    logic                                ms_tick;
    logic                                fire;
    logic                                issue;
    logic [IDX_W-1:0]                    issue_idx;
    logic [NUM_KINDS-1:0][CNT_W-1:0]     counts;

    // Index 0 (pedestal) sits in the most significant field.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_unpack
        assign counts[k] = seq_word[(NUM_KINDS-1-k)*CNT_W +: CNT_W];
    end

    ms_pacer #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_pacer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ms_tick(ms_tick)
    );

    interval_gate #(.IV_W(IV_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ms_tick(ms_tick),
        .interval(interval_ms), .fire(fire)
    );

    kind_stepper #(.NK(NUM_KINDS), .CNT_W(CNT_W)) u_step (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fire(fire),
        .counts(counts), .kind_on(kind_en),
        .issue(issue), .issue_idx(issue_idx)
    );

    // Output register: pulse, kind code and LED settings of the issued kind.
    always_ff @(posedge clk) begin
        if (!rst_n || !issue) begin
            trig_pulse <= 1'b0;
            trig_kind  <= KIND_NONE;
            led_grp    <= '0;
            led_level  <= '0;
        end else begin
            trig_pulse <= 1'b1;
            trig_kind  <= KIND_W'(issue_idx) + KIND_W'(1);
            case (issue_idx)
                IDX_W'(1): begin
                    led_grp   <= {lpint_grp_en[GRP2_BIT], lpint_grp_en[GRP1_BIT]};
                    led_level <= lpint_level;
                end
                IDX_W'(2): begin
                    led_grp   <= {lpext_grp_en[GRP2_BIT], lpext_grp_en[GRP1_BIT]};
                    led_level <= lpext_level;
                end
                default: begin
                    led_grp   <= '0;
                    led_level <= '0;
                end
            endcase
        end
    end

    if (CLK_PER_US * US_PER_MS > 1) begin : g_single
        a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            trig_pulse |=> !trig_pulse);
    end
    a_r7_kind_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (trig_kind != KIND_NONE));
    a_r7_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_pulse |-> (trig_kind == KIND_NONE && led_grp == '0));
    a_r9_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !trig_pulse);
    a_r8_pedestal_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_kind == KIND_PED) |-> (led_grp == '0 && led_level == '0));
endmodule

// File: tb/sim_art_trig_seq.sv
module sim_art_trig_seq;
    localparam int P = 2;
    localparam int U = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [9:0]  interval_ms = 10'd1;
    logic [14:0] seq_word = '0;
    logic [2:0]  kind_en = 3'b111;
    logic [7:0]  lpint_grp_en = 8'h40;
    logic [7:0]  lpext_grp_en = 8'h80;
    logic [6:0]  lpint_level = 7'd17;
    logic [6:0]  lpext_level = 7'd99;
    logic        trig_pulse;
    logic [1:0]  trig_kind;
    logic [1:0]  led_grp;
    logic [6:0]  led_level;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    art_trig_seq #(.CLK_PER_US(P), .US_PER_MS(U)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .interval_ms(interval_ms),
        .seq_word(seq_word), .kind_en(kind_en),
        .lpint_grp_en(lpint_grp_en), .lpext_grp_en(lpext_grp_en),
        .lpint_level(lpint_level), .lpext_level(lpext_level),
        .trig_pulse(trig_pulse), .trig_kind(trig_kind),
        .led_grp(led_grp), .led_level(led_level)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Run one configuration: expect npulses triggers, then idle extra edges.
    task automatic run_cfg(input int iv, input int cp, input int ci, input int ce,
                           input logic [2:0] en, input int npulses, input int extra);
        int c[3];
        int per, plen, seen, total;
        c[0] = en[0] ? cp : 0;
        c[1] = en[1] ? ci : 0;
        c[2] = en[2] ? ce : 0;
        per  = ((iv == 0) ? 1 : iv) * P * U;
        plen = c[0] + c[1] + c[2];
        interval_ms = 10'(iv);
        seq_word    = {5'(cp), 5'(ci), 5'(ce)};
        kind_en     = en;
        run_en      = 1'b1;
        seen  = 0;
        total = npulses * per + extra;
        for (int n = 1; n <= total; n++) begin
            logic due;
            @(negedge clk);
            due = (plen > 0) && (n % per == 0);
            if (due || trig_pulse) begin
                int j, pos, ek, eg, el;
                check("R2", "pulse at due edge", int'(trig_pulse), int'(due));
                if (due) begin
                    j   = n / per;
                    pos = (j - 1) % plen;
                    ek  = (pos < c[0]) ? 1 : (pos < c[0] + c[1]) ? 2 : 3;
                    eg  = (ek == 2) ? {lpint_grp_en[7], lpint_grp_en[6]} :
                          (ek == 3) ? {lpext_grp_en[7], lpext_grp_en[6]} : 0;
                    el  = (ek == 2) ? lpint_level : (ek == 3) ? lpext_level : 0;
                    check("R4", "kind order", int'(trig_kind), ek);
                    check("R8", "led group", int'(led_grp), eg);
                    check("R8", "led level", int'(led_level), el);
                end
            end
            if (trig_pulse) seen++;
        end
        check((plen == 0) ? "R6" : "R5", "pulse count", seen, (plen == 0) ? 0 : npulses);
        run_en = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            check("R9", "quiet while stopped", int'(trig_pulse), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset holds everything at zero even with run_en high.
        run_en   = 1'b1;
        seq_word = {5'd1, 5'd1, 5'd1};
        repeat (20) @(negedge clk);
        check("R1", "pulse in reset", int'(trig_pulse), 0);
        check("R1", "kind in reset", int'(trig_kind), 0);
        check("R1", "leds in reset", int'({led_grp, led_level}), 0);
        run_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R9: stopped with a valid config produces nothing.
        repeat (40) begin
            @(negedge clk);
            check("R9", "stopped no pulse", int'(trig_pulse), 0);
        end
        // R4/R5/R6/R7: sweep counts 0..2 for each kind at a 1 ms interval.
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int e = 0; e < 3; e++)
                    run_cfg(1, a, b, e, 3'b111, 2 * (a + b + e) + 1, 0);
        // R5/R6: sweep the enable mask with counts 1,2,3.
        for (int m = 0; m < 8; m++)
            run_cfg(1, 1, 2, 3, 3'(m), 8, 0);
        // R8: other LED settings.
        lpint_grp_en = 8'hC0; lpint_level = 7'd127;
        lpext_grp_en = 8'h3F; lpext_level = 7'd1;
        run_cfg(1, 1, 1, 1, 3'b111, 6, 0);
        // R3: interval 0 behaves as 1 ms; R2 at larger intervals.
        run_cfg(0, 1, 1, 1, 3'b111, 5, 0);
        run_cfg(3, 2, 0, 1, 3'b111, 4, 0);
        run_cfg(1023, 1, 1, 0, 3'b111, 2, 0);
        // R9: stop mid-pattern and mid-interval, then restart from the top.
        run_cfg(2, 2, 1, 1, 3'b111, 1, 7);
        run_cfg(2, 2, 1, 1, 3'b111, 3, 5);
        run_cfg(2, 2, 1, 1, 3'b111, 5, 0);
        // R10: the largest count of 31.
        run_cfg(1, 31, 0, 1, 3'b111, 34, 0);
        run_cfg(1, 0, 31, 31, 3'b111, 64, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule